// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Controller

This block gathers fourteen interrupt request flags from the timers, the serial port, the ADC, a software interrupt and the external pins. It folds them into twelve sources and masks each source with its own enable bit and with a global enable. It then picks one winner by priority level and polling rank. The winner's fixed vector address goes out on a registered output, together with a request line to the CPU.

Each pair of sources shares a two-bit priority level. The level is made from one bit in each of two priority registers, so there are four levels. The controller tracks which levels are currently in service. A new request can only interrupt when its level is strictly above the highest level in service. When the CPU acknowledges, the winner's level is marked in service, and the flags that hardware clears get a one-cycle clear pulse. A return-from-interrupt pulse releases the highest level in service.

Top module: `vint_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `irq_o` is 0, `insvc_o` is 0 and `flag_clr_o` is 0.
- R2: Source k (0..11) has a fixed vector. For k<6 the vector is 0003h+8k. For k>=6 it is 0043h+8(k-6). The sources in order are ext0, timer0, ext1, timer1, serial, timer2, ADC, software, ext3, ext4, ext5 and ext6.
- R3: Flag bit mapping. Bits 0..3 drive sources 0..3. Bits 4 (receive) and 5 (transmit) are ORed into the serial source. Bits 6 (timer 2 overflow) and 7 (external reload) are ORed into the timer 2 source. Bits 8..13 drive sources 6..11.
- R4: A source can request only when its bit in `src_en_i` and `glob_en_i` are both 1.
- R5: Group g (0..5) holds sources g and g+6. The group's level is {`prio_hi_i[g]`, `prio_lo_i[g]`}, where 3 is the highest. The highest-level eligible source wins.
- R6: Among eligible sources at equal level, the fixed order is ext0, ADC, timer0, software, ext1, ext3, timer1, ext4, serial, ext5, timer2, ext6. The first in this order wins.
- R7: When `ack_i` is high while `irq_o` is high, the winner's level bit is set in `insvc_o` at that edge, and `irq_o` is 0 in the following cycle. `ack_i` while `irq_o` is low has no effect.
- R8: `irq_o` rises only for a source whose level is strictly higher than the highest set bit of `insvc_o`.
- R9: A `reti_i` pulse clears only the highest set bit of `insvc_o`.
- R10: On an accepted acknowledge, `flag_clr_o` pulses for one cycle. The pulse carries the winner's flag bit if it is one of bits 0..3 or 10..13. For the serial, timer 2, ADC and software sources, `flag_clr_o` stays 0.
- R11: `irq_o` and `vec_o` are registered. They reflect the flags, enables and levels sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_i | input | 14 | Raw request flags (mapping in R3) |
| src_en_i | input | 12 | Per-source enable |
| glob_en_i | input | 1 | Global enable |
| prio_lo_i | input | 6 | Low bit of each group's level |
| prio_hi_i | input | 6 | High bit of each group's level |
| ack_i | input | 1 | CPU accepts the presented vector |
| reti_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 16 | Vector address of the winner |
| insvc_o | output | 4 | Levels in service, one bit per level |
| flag_clr_o | output | 14 | One-cycle hardware-clear pulse per flag |

## Verification
The bench walks every source through its vector. It drives the serial and timer 2 sources from each of their two flags, so a broken vector formula or a dropped OR term gives a wrong address or no request. It sets a lower-level request against a higher one that sits later in the polling order, and pairs equal-level requests from different groups. A design that compares rank before level, or resolves ties the wrong way, presents the wrong vector. Nested service checks the edges of the level rule: an equal-level request must stay blocked while a higher one interrupts. A design that lets equal levels preempt, or whose return clears every level, raises the request at the wrong time. Acknowledges of software-cleared sources check that no clear pulse is sent for them.

// File: rtl/vint_pkg.sv
package vint_pkg;
    localparam int NSRC  = 12;
    localparam int NFLAG = 14;
    localparam int NGRP  = NSRC / 2;
    localparam int LW    = 2;
    localparam int NLVL  = 1 << LW;
    localparam int VW    = 16;
    localparam int SW    = $clog2(NSRC);

    // flags that hardware clears on vectoring: ext0, t0, ext1, t1, ext3..ext6
    localparam logic [NFLAG-1:0] AUTO_CLR = 14'b11_1100_0000_1111;

    typedef logic [LW-1:0] lvl_t;

    typedef struct packed {
        logic          valid;
        logic [SW-1:0] src;
        lvl_t          lvl;
    } win_t;

    function automatic logic [VW-1:0] vec_of(input logic [SW-1:0] s);
        if (s < SW'(NGRP))
            return VW'(16'h0003) + (VW'(s) << 3);
        else
            return VW'(16'h0043) + (VW'(s - SW'(NGRP)) << 3);
    endfunction

    // polling rank -> source: even ranks take the group's first member
    function automatic int src_of_rank(input int r);
        return (r % 2 == 1) ? (r / 2 + NGRP) : (r / 2);
    endfunction

    function automatic logic [NFLAG-1:0] flags_of_src(input int s);
        logic [NFLAG-1:0] m;
        m = '0;
        if (s < 4)       m[s] = 1'b1;
        else if (s == 4) m[5:4] = 2'b11;
        else if (s == 5) m[7:6] = 2'b11;
        else             m[s + 2] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/vint_src_mask.sv
module vint_src_mask
    import vint_pkg::*;
(
    input  logic [NFLAG-1:0] flag_i,
    input  logic [NSRC-1:0]  en_i,
    input  logic             glob_i,
    output logic [NSRC-1:0]  pend_o
);
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam logic [NFLAG-1:0] SEL = flags_of_src(s);
        assign pend_o[s] = glob_i & en_i[s] & (|(flag_i & SEL));
    end
endmodule

// File: rtl/vint_arbiter.sv
module vint_arbiter
    import vint_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    input  logic [NGRP-1:0] prio_lo_i,
    input  logic [NGRP-1:0] prio_hi_i,
    input  logic [LW:0]     ceil_i,
    output win_t            win_o
);
    always_comb begin
        win_t w;
        w = '0;
        for (int r = 0; r < NSRC; r++) begin
            int   s;
            lvl_t l;
            s = src_of_rank(r);
            l = {prio_hi_i[s % NGRP], prio_lo_i[s % NGRP]};
            if (pend_i[s] && ((LW+1)'(l) + 1'b1 > ceil_i)
                && (!w.valid || l > w.lvl)) begin
                w.valid = 1'b1;
                w.src   = SW'(s);
                w.lvl   = l;
            end
        end
        win_o = w;
    end
endmodule

// File: rtl/vint_level_track.sv
module vint_level_track
    import vint_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_i,
    input  lvl_t            set_lvl_i,
    input  logic            pop_i,
    output logic [NLVL-1:0] insvc_o,
    output logic [LW:0]     ceil_o
);
    logic [NLVL-1:0] act_q;
    logic [NLVL-1:0] top_m;

    always_comb begin
        ceil_o = '0;
        top_m  = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (act_q[i]) begin
                ceil_o = (LW+1)'(i + 1);
                top_m  = '0;
                top_m[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else begin
            act_q <= (act_q & ~(pop_i ? top_m : '0))
                   | (set_i ? (NLVL'(1) << set_lvl_i) : '0);
        end
    end

    assign insvc_o = act_q;
endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
    import vint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [13:0]      flag_i,
    input  logic [11:0]      src_en_i,
    input  logic             glob_en_i,
    input  logic [5:0]       prio_lo_i,
    input  logic [5:0]       prio_hi_i,
    input  logic             ack_i,
    input  logic             reti_i,
    output logic             irq_o,
    output logic [15:0]      vec_o,
    output logic [3:0]       insvc_o,
    output logic [13:0]      flag_clr_o
);
    logic [NSRC-1:0]  pend;
    logic [LW:0]      ceil;
    win_t             win;
    logic             irq_q;
    logic [VW-1:0]    vec_q;
    lvl_t             lvl_q;
    logic [SW-1:0]    src_q;
    logic [NFLAG-1:0] clr_q;
    logic             take;

    assign take = ack_i & irq_q;

    vint_src_mask u_mask (
        .flag_i (flag_i),
        .en_i   (src_en_i),
        .glob_i (glob_en_i),
        .pend_o (pend)
    );

    vint_arbiter u_arb (
        .pend_i    (pend),
        .prio_lo_i (prio_lo_i),
        .prio_hi_i (prio_hi_i),
        .ceil_i    (ceil),
        .win_o     (win)
    );

    vint_level_track u_lvl (
        .clk       (clk),
        .rst       (rst),
        .set_i     (take),
        .set_lvl_i (lvl_q),
        .pop_i     (reti_i),
        .insvc_o   (insvc_o),
        .ceil_o    (ceil)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            vec_q <= '0;
            lvl_q <= '0;
            src_q <= '0;
            clr_q <= '0;
        end else begin
            clr_q <= '0;
            if (take) begin
                irq_q <= 1'b0;
                clr_q <= flags_of_src(int'(src_q)) & AUTO_CLR;
            end else begin
                irq_q <= win.valid;
                vec_q <= vec_of(win.src);
                lvl_q <= win.lvl;
                src_q <= win.src;
            end
        end
    end

    assign irq_o      = irq_q;
    assign vec_o      = vec_q;
    assign flag_clr_o = clr_q;
endmodule

// File: rtl/vint_ctrl_chk.sv
module vint_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        glob_en_i,
    input logic        ack_i,
    input logic        reti_i,
    input logic        irq_o,
    input logic [15:0] vec_o,
    input logic [3:0]  insvc_o,
    input logic [13:0] flag_clr_o
);
    // R4
    glob_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(glob_en_i));

    // R2
    vec_align_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> vec_o[2:0] == 3'b011);

    // R7
    ack_take_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && irq_o) |=> (insvc_o != 4'd0 && !irq_o));

    // R10
    clr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_o != 14'd0) |-> $past(ack_i && irq_o));

    // R10
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flag_clr_o));

    // R9
    reti_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (reti_i && !ack_i && insvc_o != 4'd0) |=>
            ($countones(insvc_o) + 1 == $countones($past(insvc_o))));
endmodule

bind vint_ctrl vint_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .glob_en_i  (glob_en_i),
    .ack_i      (ack_i),
    .reti_i     (reti_i),
    .irq_o      (irq_o),
    .vec_o      (vec_o),
    .insvc_o    (insvc_o),
    .flag_clr_o (flag_clr_o)
);

// File: tb/vint_ctrl_bench.sv
module vint_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [13:0] flag_i;
    logic [11:0] src_en_i;
    logic        glob_en_i;
    logic [5:0]  prio_lo_i;
    logic [5:0]  prio_hi_i;
    logic        ack_i;
    logic        reti_i;
    logic        irq_o;
    logic [15:0] vec_o;
    logic [3:0]  insvc_o;
    logic [13:0] flag_clr_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    vint_ctrl u_vint_ctrl (
        .clk(clk), .rst(rst), .flag_i(flag_i), .src_en_i(src_en_i),
        .glob_en_i(glob_en_i), .prio_lo_i(prio_lo_i), .prio_hi_i(prio_hi_i),
        .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o), .vec_o(vec_o),
        .insvc_o(insvc_o), .flag_clr_o(flag_clr_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(input int s);
        return (s < 6) ? 16'(16'h0003 + 8 * s) : 16'(16'h0043 + 8 * (s - 6));
    endfunction

    function automatic int flag_bit(input int s);
        if (s < 4) return s;
        if (s == 4) return 5;
        if (s == 5) return 7;
        return s + 2;
    endfunction

    task automatic do_ack();
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
    endtask

    task automatic do_reti();
        reti_i = 1'b1;
        tick();
        reti_i = 1'b0;
    endtask

    task automatic idle_all();
        flag_i = '0; src_en_i = '1; glob_en_i = 1'b1;
        prio_lo_i = '0; prio_hi_i = '0;
        tick(); tick();
    endtask

    task automatic t_reset();
        check("R1 irq", irq_o, 0);
        check("R1 insvc", insvc_o, 0);
        check("R1 clr", flag_clr_o, 0);
    endtask

    task automatic t_vectors();
        idle_all();
        for (int s = 0; s < 12; s++) begin
            flag_i = '0;
            flag_i[flag_bit(s)] = 1'b1;
            tick();
            check("R2 irq", irq_o, 1);
            check("R2 vector", vec_o, exp_vec(s));
        end
        flag_i = 14'h0010;  // R3 receive flag
        tick();
        check("R3 serial rx", vec_o, 16'h0023);
        flag_i = 14'h0040;  // R3 timer2 overflow flag
        tick();
        check("R3 timer2 ovf", vec_o, 16'h002B);
        flag_i = '0;
        tick();
        check("R3 idle", irq_o, 0);
    endtask

    task automatic t_mask();
        idle_all();
        src_en_i[0] = 1'b0;
        flag_i = 14'h0001;
        tick();
        check("R4 source disabled", irq_o, 0);
        src_en_i[0] = 1'b1;
        glob_en_i = 1'b0;
        tick();
        check("R4 global off", irq_o, 0);
        glob_en_i = 1'b1;
        #1;
        check("R11 not before edge", irq_o, 0);
        tick();
        check("R11 after edge", irq_o, 1);
        check("R4 vec", vec_o, 16'h0003);
        flag_i = '0;
        tick();
    endtask

    task automatic t_prio();
        idle_all();
        prio_hi_i[5] = 1'b1; prio_lo_i[5] = 1'b1;  // ext6 level 3
        flag_i = 14'h2001;                          // ext0 + ext6
        tick();
        check("R5 level 3 wins", vec_o, 16'h006B);
        prio_lo_i = '0; prio_hi_i = '0;
        prio_lo_i[1] = 1'b1;                        // t0/swi level 1
        flag_i = 14'h0101;                          // ext0 + adc
        flag_i[1] = 1'b1;                           // t0
        tick();
        check("R5 level 1 over 0", vec_o, 16'h000B);
    endtask

    task automatic t_poll();
        idle_all();
        flag_i = 14'h0102;                          // t0 + adc
        tick();
        check("R6 adc before t0", vec_o, 16'h0043);
        flag_i = 14'h2001;                          // ext0 + ext6
        tick();
        check("R6 ext0 before ext6", vec_o, 16'h0003);
        flag_i = 14'h2040;                          // t2 + ext6
        tick();
        check("R6 t2 before ext6", vec_o, 16'h002B);
        flag_i = 14'h0220;                          // tx + swi
        tick();
        check("R6 swi before serial", vec_o, 16'h004B);
        flag_i = '0;
        tick();
    endtask

    task automatic t_nest();
        idle_all();
        prio_lo_i[1] = 1'b1;  // t0 level 1
        prio_lo_i[2] = 1'b1;  // ext1 level 1
        prio_hi_i[3] = 1'b1;  // t1 level 2
        ack_i = 1'b1;         // R7 ack with no request
        tick();
        ack_i = 1'b0;
        check("R7 stray ack", insvc_o, 0);
        flag_i = 14'h0002;
        tick();
        check("R8 t0 request", vec_o, 16'h000B);
        do_ack();
        check("R7 insvc level1", insvc_o, 4'b0010);
        check("R7 irq drops", irq_o, 0);
        check("R10 t0 cleared", flag_clr_o, 14'h0002);
        flag_i = 14'h0005;    // ext1 (level 1) + ext0 (level 0)
        tick(); tick();
        check("R8 equal and lower blocked", irq_o, 0);
        check("R10 pulse one cycle", flag_clr_o, 0);
        flag_i[3] = 1'b1;     // t1 level 2
        tick();
        check("R8 higher preempts", irq_o, 1);
        check("R8 t1 vector", vec_o, 16'h001B);
        do_ack();
        check("R7 insvc levels 1,2", insvc_o, 4'b0110);
        check("R10 t1 cleared", flag_clr_o, 14'h0008);
        flag_i[3] = 1'b0;
        flag_i[0] = 1'b0;
        tick();
        do_reti();
        check("R9 pop top only", insvc_o, 4'b0010);
        tick();
        check("R9 ext1 still blocked", irq_o, 0);
        do_reti();
        check("R9 all free", insvc_o, 0);
        tick();
        check("R8 ext1 now served", vec_o, 16'h0013);
        check("R8 ext1 irq", irq_o, 1);
        do_ack();
        do_reti();
        flag_i = 14'h0010;    // serial rx, level 0
        tick();
        check("R10 serial request", vec_o, 16'h0023);
        do_ack();
        check("R10 serial not cleared", flag_clr_o, 0);
        check("R7 insvc level0", insvc_o, 4'b0001);
        do_reti();
        flag_i = '0;
        tick();
    endtask

    initial begin
        rst = 1'b1; flag_i = '0; src_en_i = '0; glob_en_i = 1'b0;
        prio_lo_i = '0; prio_hi_i = '0; ack_i = 1'b0; reti_i = 1'b0;
        tick(); tick();
        t_reset();
        rst = 1'b0;
        tick();
        t_reset();
        t_vectors();
        t_mask();
        t_prio();
        t_poll();
        t_nest();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule